// File: doc/BRIEF.md
# Interrupt Unit Mode Controller

This block keeps the base-control register of a local interrupt unit. The register holds a physical base address field, a global enable bit, an extended-mode bit and a bootstrap-processor bit. The unit can be in one of three modes, given by the pair {enable, extended}: off (00), legacy (10) or extended (11). The pair 01 is never allowed.

Every write request is checked against the allowed mode moves before it is committed. A write that breaks a rule is dropped and reported on a one-cycle error strobe. A write that clears the enable bit also pulses a request to clear the software-enable bit that a neighbouring register holds. On each move into extended mode, the block computes a logical ID from the unit's initial ID and holds it on an output. Decoding of the register bus is handled outside this block.

Top module: `iu_mode_ctrl`

## Requirements
- R1: A write with value bit 10 (extended) set is rejected when `ext_supported_i` is low.
- R2: A write with bit 10 set and bit 11 (enable) clear is rejected.
- R3: A write with both bits 10 and 11 set is rejected while the unit is off (enable and extended both clear).
- R4: A write with bit 11 set and bit 10 clear is rejected while the unit is in extended mode.
- R5: After a rejected write, `wr_err_o` is high for exactly the next cycle and `base_reg_o` does not change.
- R6: An accepted write loads the base field `base_reg_o[31:12]` from value bits 31:12 and loads enable (bit 11) and extended (bit 10) from the same bits of the value. The bootstrap bit (bit 8) does not change. All other register bits read zero, whatever the written value holds in them.
- R7: An accepted write with bit 11 clear pulses `sw_en_clr_o` for one cycle.
- R8: An accepted write that moves the unit from a non-extended mode into extended mode pulses `ext_entry_o` for one cycle. It also loads `log_id_o` with `init_id_i[19:4]` in bits 31:16 and a single one at bit position `init_id_i[3:0]`. In every other case `log_id_o` holds its value.
- R9: Reset sets the unit to legacy mode with base field 0xFEE00, sets the bootstrap bit from `boot_strap_i`, and clears `log_id_o` and all strobes.
- R10: The register and the strobes change only on the clock edge at which `wr_en_i` is high, and the new values are seen after that edge. Without a write the register holds and all strobes stay low.
- R11: Moves from off to legacy, from legacy to off, from legacy to extended (when supported), from extended to off, and from extended to extended are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_strap_i | input | 1 | Bootstrap-processor strap, loaded into bit 8 at reset |
| ext_supported_i | input | 1 | High when extended mode is allowed |
| init_id_i | input | 32 | Initial unit ID, the source of the logical ID |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write value |
| base_reg_o | output | 64 | Current register value |
| wr_err_o | output | 1 | One-cycle pulse after a rejected write |
| sw_en_clr_o | output | 1 | One-cycle request to clear the software-enable bit |
| ext_entry_o | output | 1 | One-cycle pulse on entry to extended mode |
| log_id_o | output | 32 | Derived extended logical ID |

## Verification
The hardest states to reach are the two forbidden moves that depend on the current mode: from off straight to extended, and from extended back to legacy. Each needs a chain of accepted writes to set up the starting mode before the illegal write is issued. The stimulus table therefore walks a sequence that passes through every mode: legacy, off, a blocked jump to extended, legacy, extended, a blocked return to legacy, then off. At each step it checks the register, every strobe and the held logical ID. Directed tests after the table cover reset with both strap values and logical-ID derivation at slot positions 0 and 15.

// File: rtl/iu_mode_pkg.sv
package iu_mode_pkg;

   // Mode encoding is {enable, extended}
   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_BAD    = 2'b01,
      MODE_LEGACY = 2'b10,
      MODE_EXT    = 2'b11
   } iu_mode_e;

   typedef enum logic [2:0] {
      REJ_NONE,
      REJ_NO_CAP,
      REJ_EXT_NO_EN,
      REJ_OFF_TO_EXT,
      REJ_EXT_TO_LEGACY
   } iu_reject_e;

   function automatic iu_mode_e mode_of(input logic en, input logic ext);
      return iu_mode_e'({en, ext});
   endfunction

endpackage

// File: rtl/iu_mode_check.sv
module iu_mode_check
   import iu_mode_pkg::*;
(
   input  iu_mode_e cur_mode,
   input  logic     req_en,
   input  logic     req_ext,
   input  logic     ext_cap,
   output logic     accept
);

   iu_reject_e cause;

   // Rules are checked in a fixed order; the first one that matches wins
   always_comb begin
      cause = REJ_NONE;
      if (req_ext && !ext_cap)
         cause = REJ_NO_CAP;
      else if (req_ext && !req_en)
         cause = REJ_EXT_NO_EN;
      else if ((cur_mode == MODE_OFF) && req_en && req_ext)
         cause = REJ_OFF_TO_EXT;
      else if ((cur_mode == MODE_EXT) && req_en && !req_ext)
         cause = REJ_EXT_TO_LEGACY;
   end

   assign accept = (cause == REJ_NONE);

endmodule

// File: rtl/iu_logid_gen.sv
module iu_logid_gen #(
   parameter int ID_W      = 32,
   parameter int SLOT_W    = 4,
   parameter int CLUSTER_W = 16,
   localparam int SLOTS    = 1 << SLOT_W,
   localparam int LID_W    = CLUSTER_W + SLOTS
) (
   input  logic [ID_W-1:0]  id,
   output logic [LID_W-1:0] lid
);

   logic [SLOT_W-1:0] slot;

   assign slot = id[SLOT_W-1:0];
   assign lid[LID_W-1:SLOTS] = id[SLOT_W+CLUSTER_W-1:SLOT_W];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign lid[s] = (slot == SLOT_W'(s));
   end

endmodule

// File: rtl/iu_mode_reg.sv
module iu_mode_reg
   import iu_mode_pkg::*;
#(
   parameter int          ADDR_W     = 20,
   parameter int          LID_W      = 32,
   parameter logic [19:0] RESET_ADDR = 20'hFEE00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_strap,
   input  logic              wr,
   input  logic              accept,
   input  logic              req_en,
   input  logic              req_ext,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LID_W-1:0]  lid_next,
   output iu_mode_e          mode,
   output logic              boot,
   output logic [ADDR_W-1:0] addr,
   output logic              err_p,
   output logic              clr_p,
   output logic              entry_p,
   output logic [LID_W-1:0]  lid
);

   logic en_q, ext_q;
   logic commit, entering;

   assign mode     = mode_of(en_q, ext_q);
   assign commit   = wr && accept;
   assign entering = commit && req_ext && !ext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b1;
         ext_q   <= 1'b0;
         boot    <= boot_strap;
         addr    <= ADDR_W'(RESET_ADDR);
         err_p   <= 1'b0;
         clr_p   <= 1'b0;
         entry_p <= 1'b0;
         lid     <= '0;
      end else begin
         err_p   <= wr && !accept;
         clr_p   <= commit && !req_en;
         entry_p <= entering;
         if (commit) begin
            en_q  <= req_en;
            ext_q <= req_ext;
            addr  <= req_addr;
         end
         if (entering)
            lid <= lid_next;
      end
   end

endmodule

// File: rtl/iu_mode_ctrl.sv
module iu_mode_ctrl
   import iu_mode_pkg::*;
#(
   parameter int          VAL_W      = 64,
   parameter int          ID_W       = 32,
   parameter int          ADDR_LSB   = 12,
   parameter int          ADDR_MSB   = 31,
   parameter int          BOOT_BIT   = 8,
   parameter int          EXT_BIT    = 10,
   parameter int          EN_BIT     = 11,
   parameter int          SLOT_W     = 4,
   parameter int          CLUSTER_W  = 16,
   parameter logic [19:0] RESET_ADDR = 20'hFEE00,
   localparam int         ADDR_W     = ADDR_MSB - ADDR_LSB + 1,
   localparam int         LID_W      = CLUSTER_W + (1 << SLOT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_strap_i,
   input  logic             ext_supported_i,
   input  logic [ID_W-1:0]  init_id_i,
   input  logic             wr_en_i,
   input  logic [VAL_W-1:0] wr_data_i,
   output logic [VAL_W-1:0] base_reg_o,
   output logic             wr_err_o,
   output logic             sw_en_clr_o,
   output logic             ext_entry_o,
   output logic [LID_W-1:0] log_id_o
);

   // Elaboration-time parameter checks
   if (ADDR_MSB >= VAL_W) begin : g_bad_msb
      $error("address field exceeds the value width");
   end
   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("address field width must be 1 to 20");
   end
   if (BOOT_BIT >= ADDR_LSB || EXT_BIT >= ADDR_LSB || EN_BIT >= ADDR_LSB) begin : g_bad_ctl
      $error("control bits must lie below the address field");
   end
   if (BOOT_BIT == EXT_BIT || BOOT_BIT == EN_BIT || EXT_BIT == EN_BIT) begin : g_bad_dup
      $error("control bits must be distinct");
   end
   if (ID_W < SLOT_W + CLUSTER_W) begin : g_bad_id
      $error("initial ID too narrow for the logical ID fields");
   end

   iu_mode_e          mode;
   logic              accept;
   logic              boot;
   logic [ADDR_W-1:0] addr;
   logic [LID_W-1:0]  lid_next;

   iu_mode_check u_check (
      .cur_mode (mode),
      .req_en   (wr_data_i[EN_BIT]),
      .req_ext  (wr_data_i[EXT_BIT]),
      .ext_cap  (ext_supported_i),
      .accept   (accept)
   );

   iu_logid_gen #(
      .ID_W      (ID_W),
      .SLOT_W    (SLOT_W),
      .CLUSTER_W (CLUSTER_W)
   ) u_logid (
      .id  (init_id_i),
      .lid (lid_next)
   );

   iu_mode_reg #(
      .ADDR_W     (ADDR_W),
      .LID_W      (LID_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .boot_strap (boot_strap_i),
      .wr         (wr_en_i),
      .accept     (accept),
      .req_en     (wr_data_i[EN_BIT]),
      .req_ext    (wr_data_i[EXT_BIT]),
      .req_addr   (wr_data_i[ADDR_MSB:ADDR_LSB]),
      .lid_next   (lid_next),
      .mode       (mode),
      .boot       (boot),
      .addr       (addr),
      .err_p      (wr_err_o),
      .clr_p      (sw_en_clr_o),
      .entry_p    (ext_entry_o),
      .lid        (log_id_o)
   );

   always_comb begin
      base_reg_o                    = '0;
      base_reg_o[ADDR_MSB:ADDR_LSB] = addr;
      base_reg_o[EN_BIT]            = mode[1];
      base_reg_o[EXT_BIT]           = mode[0];
      base_reg_o[BOOT_BIT]          = boot;
   end

endmodule

// File: rtl/iu_mode_ctrl_chk.sv
module iu_mode_ctrl_chk #(
   parameter int VAL_W     = 64,
   parameter int ID_W      = 32,
   parameter int BOOT_BIT  = 8,
   parameter int EXT_BIT   = 10,
   parameter int EN_BIT    = 11,
   parameter int SLOT_W    = 4,
   parameter int CLUSTER_W = 16,
   localparam int SLOTS    = 1 << SLOT_W,
   localparam int LID_W    = CLUSTER_W + SLOTS
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ext_supported_i,
   input logic             wr_en_i,
   input logic [ID_W-1:0]  init_id_i,
   input logic [VAL_W-1:0] base_reg_o,
   input logic             wr_err_o,
   input logic             sw_en_clr_o,
   input logic             ext_entry_o,
   input logic [LID_W-1:0] log_id_o
);

   logic en, ext;
   assign en  = base_reg_o[EN_BIT];
   assign ext = base_reg_o[EXT_BIT];

   a_r1_ext_needs_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext) |-> $past(ext_supported_i));

   a_r2_no_ext_without_en: assert property (@(posedge clk) disable iff (!rst_n)
      ext |-> en);

   a_r3_no_off_to_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ext) |=> !(en && ext));

   a_r4_no_ext_to_legacy: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ext) |=> !(en && !ext));

   a_r5_err_holds_reg: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err_o |-> ($stable(base_reg_o) && $past(wr_en_i)));

   a_r6_boot_stable: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(base_reg_o[BOOT_BIT]));

   a_r7_clr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      sw_en_clr_o |-> (!en && !wr_err_o));

   a_r8_entry_slot: assert property (@(posedge clk) disable iff (!rst_n)
      ext_entry_o |-> ($onehot(log_id_o[SLOTS-1:0]) && ext));

   a_r8_entry_cluster: assert property (@(posedge clk) disable iff (!rst_n)
      ext_entry_o |-> (log_id_o[LID_W-1:SLOTS] == $past(init_id_i[SLOT_W+CLUSTER_W-1:SLOT_W])));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en_i) |-> ($stable(base_reg_o) && !wr_err_o && !sw_en_clr_o && !ext_entry_o));

endmodule

bind iu_mode_ctrl iu_mode_ctrl_chk #(
   .VAL_W     (VAL_W),
   .ID_W      (ID_W),
   .BOOT_BIT  (BOOT_BIT),
   .EXT_BIT   (EXT_BIT),
   .EN_BIT    (EN_BIT),
   .SLOT_W    (SLOT_W),
   .CLUSTER_W (CLUSTER_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ext_supported_i (ext_supported_i),
   .wr_en_i         (wr_en_i),
   .init_id_i       (init_id_i),
   .base_reg_o      (base_reg_o),
   .wr_err_o        (wr_err_o),
   .sw_en_clr_o     (sw_en_clr_o),
   .ext_entry_o     (ext_entry_o),
   .log_id_o        (log_id_o)
);

// File: tb/tb_iu_mode_ctrl.sv
module tb_iu_mode_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_strap_i = 1'b1;
   logic        ext_supported_i = 1'b0;
   logic [31:0] init_id_i = 32'h000A_BC57;
   logic        wr_en_i = 1'b0;
   logic [63:0] wr_data_i = '0;
   logic [63:0] base_reg_o;
   logic        wr_err_o, sw_en_clr_o, ext_entry_o;
   logic [31:0] log_id_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   iu_mode_ctrl dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .boot_strap_i    (boot_strap_i),
      .ext_supported_i (ext_supported_i),
      .init_id_i       (init_id_i),
      .wr_en_i         (wr_en_i),
      .wr_data_i       (wr_data_i),
      .base_reg_o      (base_reg_o),
      .wr_err_o        (wr_err_o),
      .sw_en_clr_o     (sw_en_clr_o),
      .ext_entry_o     (ext_entry_o),
      .log_id_o        (log_id_o)
   );

   typedef struct packed {
      logic [63:0] wd;
      logic        sup;
      logic [31:0] exp_reg;
      logic        exp_err;
      logic        exp_clr;
      logic        exp_ent;
      logic [31:0] exp_lid;
      logic [7:0]  req;
   } vec_t;

   // init_id 0x000ABC57 -> logical ID 0xABC50080
   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{64'h0000_0000_1234_5C00, 1'b0, 32'hFEE0_0900, 1'b1, 1'b0, 1'b0, 32'h0,         8'd1},
      '{64'h0000_0000_1234_5400, 1'b1, 32'hFEE0_0900, 1'b1, 1'b0, 1'b0, 32'h0,         8'd2},
      '{64'hFFFF_FFFF_1234_5A00, 1'b1, 32'h1234_5900, 1'b0, 1'b0, 1'b0, 32'h0,         8'd6},
      '{64'h0000_0000_0000_0000, 1'b1, 32'h0000_0100, 1'b0, 1'b1, 1'b0, 32'h0,         8'd7},
      '{64'h0000_0000_ABCD_EC00, 1'b1, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 32'h0,         8'd3},
      '{64'h0000_0000_ABCD_E800, 1'b1, 32'hABCD_E900, 1'b0, 1'b0, 1'b0, 32'h0,         8'd11},
      '{64'h0000_0000_ABCD_EC00, 1'b1, 32'hABCD_ED00, 1'b0, 1'b0, 1'b1, 32'hABC5_0080, 8'd8},
      '{64'h0000_0000_5555_5800, 1'b1, 32'hABCD_ED00, 1'b1, 1'b0, 1'b0, 32'hABC5_0080, 8'd4},
      '{64'h0000_0000_5555_5C00, 1'b1, 32'h5555_5D00, 1'b0, 1'b0, 1'b0, 32'hABC5_0080, 8'd11},
      '{64'h0000_0000_0000_0400, 1'b1, 32'h5555_5D00, 1'b1, 1'b0, 1'b0, 32'hABC5_0080, 8'd2},
      '{64'h0000_0000_1111_1000, 1'b1, 32'h1111_1100, 1'b0, 1'b1, 1'b0, 32'hABC5_0080, 8'd7},
      '{64'h0000_0000_2222_2800, 1'b1, 32'h2222_2900, 1'b0, 1'b0, 1'b0, 32'hABC5_0080, 8'd11},
      '{64'h0000_0000_3333_3C00, 1'b0, 32'h2222_2900, 1'b1, 1'b0, 1'b0, 32'hABC5_0080, 8'd1}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0;
      boot_strap_i = strap;
      wr_en_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_write(input logic [63:0] d, input logic sup);
      wr_data_i = d;
      ext_supported_i = sup;
      wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R9: reset state, strap high
      do_reset(1'b1);
      check("R9 reg", base_reg_o, 64'h0000_0000_FEE0_0900);
      check("R9 err", {63'b0, wr_err_o}, 64'h0);
      check("R9 clr", {63'b0, sw_en_clr_o}, 64'h0);
      check("R9 entry", {63'b0, ext_entry_o}, 64'h0);
      check("R9 lid", {32'b0, log_id_o}, 64'h0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         string tag;
         do_write(VEC[i].wd, VEC[i].sup);
         tag = $sformatf("R%0d step%0d", VEC[i].req, i);
         check({tag, " reg"}, base_reg_o, {32'b0, VEC[i].exp_reg});
         check({tag, " err R5"}, {63'b0, wr_err_o}, {63'b0, VEC[i].exp_err});
         check({tag, " clr R7"}, {63'b0, sw_en_clr_o}, {63'b0, VEC[i].exp_clr});
         check({tag, " entry R8"}, {63'b0, ext_entry_o}, {63'b0, VEC[i].exp_ent});
         check({tag, " lid R8"}, {32'b0, log_id_o}, {32'b0, VEC[i].exp_lid});
      end

      // R5 and R10: error pulse lasts one cycle, idle cycle leaves register alone
      idle_cycle();
      check("R5 err pulse ends", {63'b0, wr_err_o}, 64'h0);
      check("R10 idle reg holds", base_reg_o, 64'h0000_0000_2222_2900);
      wr_data_i = 64'h0000_0000_0000_0000;
      idle_cycle();
      check("R10 no strobe no change", base_reg_o, 64'h0000_0000_2222_2900);
      check("R10 no clr without strobe", {63'b0, sw_en_clr_o}, 64'h0);

      // R9: reset with strap low
      do_reset(1'b0);
      check("R9 strap low reg", base_reg_o, 64'h0000_0000_FEE0_0800);
      check("R9 lid cleared", {32'b0, log_id_o}, 64'h0);

      // R8: slot 0 derivation, R11 legacy to extended
      init_id_i = 32'h0000_0000;
      do_write(64'h0000_0000_FEE0_0C00, 1'b1);
      check("R8 slot0 lid", {32'b0, log_id_o}, 64'h0000_0000_0000_0001);
      check("R11 legacy to ext", base_reg_o, 64'h0000_0000_FEE0_0C00);
      init_id_i = 32'h1234_5678;
      idle_cycle();
      check("R8 entry pulse ends", {63'b0, ext_entry_o}, 64'h0);
      check("R8 lid holds", {32'b0, log_id_o}, 64'h0000_0000_0000_0001);
      // R11: extended to off, R7 clear pulse
      do_write(64'h0000_0000_0000_0000, 1'b1);
      check("R11 ext to off", base_reg_o, 64'h0);
      check("R7 clr from ext", {63'b0, sw_en_clr_o}, 64'h1);

      // R8: slot 15 with full cluster field
      do_reset(1'b1);
      init_id_i = 32'hFF0F_FFFF;
      do_write(64'h0000_0000_0000_0C00, 1'b1);
      check("R8 slot15 lid", {32'b0, log_id_o}, 64'h0000_0000_FFFF_8000);
      check("R8 entry pulse", {63'b0, ext_entry_o}, 64'h1);
      check("R6 boot kept", base_reg_o, 64'h0000_0000_0000_0D00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule